// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is the slave side of a two-wire serial bus (I2C-style) wrapped around a byte-wide memory array. The external master supplies every clock. The block samples the clock and data lines against its own system clock and detects Start and Stop conditions. It answers only to its own device address, which is a fixed prefix followed by three strap bits. After the address it accepts a two-byte word address. It then stores written bytes, or streams bytes out for reads.

Writes land in the array while the acknowledge clock is still running. No transaction is ever refused for being busy, and the master never has to poll for completion. The word address on the bus is 16 bits wide. Only the low `ADDR_W` bits select a location: 15 bits for the full 32,768-byte array, and 10 bits by default so that the array stays small in simulation. The internal pointer steps forward after every byte moved and wraps from the top location back to zero.

The data line is open-drain. The block has one output that asks for the line to be pulled low, and the board supplies the pull-up.

Top module: `fram_twi_slave`

## Requirements
- R1: A synchronous active-high reset releases the data line (`sda_pull_o` = 0) and returns the interface to idle, including when reset arrives in the middle of a read byte.
- R2: A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. A Start begins address matching and a Stop returns to idle. Both release the data line on the following clock.
- R3: The device byte is `1010`, then `strap_i[2]`, `strap_i[1]`, `strap_i[0]`, then the read/write bit (1 = read), sent MSB first. On a match the slave pulls SDA low during the ninth SCL pulse. On a mismatch it leaves SDA released for the rest of that transaction.
- R4: After a write-direction device byte, two bytes follow that form a 16-bit word address, high byte first. Bits above `ADDR_W` are ignored, so 0xFC12 and 0x0012 select the same location when `ADDR_W` is 10. Each address byte is acknowledged.
- R5: Each data byte written after the word address is stored at the pointer and acknowledged. A new write transaction that starts right after a Stop is acknowledged as well, because the slave never reports busy.
- R6: A read-direction device byte makes the slave send bytes MSB first, beginning with the byte at the pointer. Each bit is changed only while SCL is low. The pointer advances after each byte written or read.
- R7: The pointer wraps from 2^`ADDR_W`−1 to 0 on both sequential writes and sequential reads.
- R8: A read with no address phase before it (Start, then a read-direction device byte) starts at the current pointer, which is the location after the last byte that was moved.
- R9: When the master does not acknowledge a read byte (SDA high on the ninth pulse), the slave stops sending and keeps SDA released until the next Start.
- R10: A Start or Stop in the middle of a byte abandons that byte without writing it. After a Start the slave is matching a device byte again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every bus line is sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, as driven by the master |
| sda_i | input | 1 | Resolved level of the bus data line |
| strap_i | input | 3 | Address strap bits, forming device address bits 3..1 |
| sda_pull_o | output | 1 | 1 = pull the data line low (open-drain drive) |

## Verification
Write-then-read pairs run from a table. Their addresses are spread across the array, and one of them has high bits set that the decoder must drop. A readback at a different address that aliases to the same location is what shows those bits are ignored. A three-byte write and read across the top of the array separates correct wrapping from saturation or spill. The read that follows, with no address phase, shows whether the pointer was kept. Device bytes with the wrong strap, bytes cut short by a Stop or Start, clocks sent after a master NACK, and a reset during a read byte each check that the slave stays silent and that the array is left unchanged.

// File: rtl/fram_twi_pkg.sv
package fram_twi_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_TXACK
  } twi_state_e;

  typedef enum logic [1:0] {
    P_DEV,
    P_AHI,
    P_ALO,
    P_DATA
  } twi_phase_e;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;
endpackage

// File: rtl/twi_line_sampler.sv
module twi_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_bit,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sh, sda_sh;
  logic scl_d, sda_d;
  logic scl_now, sda_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[TOP-1:0], scl_i};
      sda_sh <= {sda_sh[TOP-1:0], sda_i};
      scl_d  <= scl_sh[TOP];
      sda_d  <= sda_sh[TOP];
    end
  end

  assign scl_now   = scl_sh[TOP];
  assign sda_now   = sda_sh[TOP];
  assign sda_bit   = sda_now;
  assign scl_rise  = scl_now & ~scl_d;
  assign scl_fall  = ~scl_now & scl_d;
  assign start_det = scl_now & scl_d & sda_d & ~sda_now;
  assign stop_det  = scl_now & scl_d & ~sda_d & sda_now;
endmodule

// File: rtl/byte_store.sv
module byte_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import fram_twi_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_bit,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        strap,
  input  logic [7:0]        rd_byte,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] ptr,
  output logic              sda_pull
);
  twi_state_e state;
  twi_phase_e phase;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txsh, ahi;
  logic       go_tx, more;
  logic       byte_done;

  assign byte_done = (state == S_RX) && scl_fall && (bitcnt == 4'd8);
  assign mem_we    = byte_done && (phase == P_DATA) && !start_det && !stop_det;
  assign mem_wdata = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      phase    <= P_DEV;
      bitcnt   <= '0;
      shreg    <= '0;
      txsh     <= '0;
      ahi      <= '0;
      go_tx    <= 1'b0;
      more     <= 1'b0;
      ptr      <= '0;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      state    <= S_RX;
      phase    <= P_DEV;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      state    <= S_IDLE;
      sda_pull <= 1'b0;
    end else begin
      unique case (state)
        S_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_bit};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            state    <= S_ACK;
            sda_pull <= 1'b1;
            go_tx    <= 1'b0;
            unique case (phase)
              P_DEV: begin
                if (shreg[7:1] == {DEV_PREFIX, strap}) begin
                  go_tx <= shreg[0];
                  phase <= P_AHI;
                end else begin
                  state    <= S_IDLE;
                  sda_pull <= 1'b0;
                end
              end
              P_AHI: begin
                ahi   <= shreg;
                phase <= P_ALO;
              end
              P_ALO: begin
                ptr   <= ADDR_W'({ahi, shreg});
                phase <= P_DATA;
              end
              default: ptr <= ptr + 1'b1;
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (go_tx) begin
              txsh     <= rd_byte;
              sda_pull <= ~rd_byte[7];
              state    <= S_TX;
            end else begin
              sda_pull <= 1'b0;
              state    <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_pull <= 1'b0;
              state    <= S_TXACK;
              ptr      <= ptr + 1'b1;
            end else begin
              txsh     <= {txsh[6:0], 1'b0};
              sda_pull <= ~txsh[6];
              bitcnt   <= bitcnt + 4'd1;
            end
          end
        end
        S_TXACK: begin
          if (scl_rise) begin
            more <= ~sda_bit;
          end else if (scl_fall) begin
            if (more) begin
              txsh     <= rd_byte;
              sda_pull <= ~rd_byte[7];
              bitcnt   <= '0;
              state    <= S_TX;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fram_twi_slave.sv
module fram_twi_slave #(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_pull_o
);
  logic              sda_bit, scl_rise, scl_fall, start_det, stop_det;
  logic              mem_we;
  logic [7:0]        mem_wdata, rd_byte;
  logic [ADDR_W-1:0] ptr;

  twi_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) smp_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_bit(sda_bit), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_slave_fsm #(.ADDR_W(ADDR_W)) fsm_i (
    .clk(clk), .rst(rst), .sda_bit(sda_bit), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap(strap_i), .rd_byte(rd_byte), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .ptr(ptr), .sda_pull(sda_pull_o)
  );

  byte_store #(.ADDR_W(ADDR_W), .DATA_W(8)) mem_i (
    .clk(clk), .we(mem_we), .addr(ptr), .wdata(mem_wdata), .rdata(rd_byte)
  );
endmodule

// File: rtl/fram_twi_slave_chk.sv
module fram_twi_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_pull_o,
  input logic mem_we,
  input logic start_det,
  input logic stop_det
);
  // R1
  rst_release_chk: assert property (@(posedge clk) rst |=> !sda_pull_o);

  // R2
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_pull_o);

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull_o);

  // R5
  write_acked_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> sda_pull_o);

  // R6
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> !scl_i);
endmodule

bind fram_twi_slave fram_twi_slave_chk chk_i (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .mem_we(mem_we), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/fram_twi_slave_tb_top.sv
`timescale 1ns/1ps
module fram_twi_slave_tb_top;
  localparam int H  = 16;
  localparam int Q  = 4;
  localparam int WD = 150000;
  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;
  // {address[15:0], data[7:0]}
  localparam logic [23:0] VECS [6] = '{
    24'h0001_5A, 24'h0123_C3, 24'hFC12_81,
    24'h03FF_E7, 24'h0200_3C, 24'h0010_66
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  wire  sda_bus = sda_m & ~sda_pull;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  fram_twi_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
    .strap_i(3'b101), .sda_pull_o(sda_pull)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H); scl = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H); scl = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; tick(H); scl = 1'b1; tick(H/2);
    b = sda_bus; tick(H/2); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(~m_ack);
  endtask

  task automatic set_addr(input logic [15:0] a, input string req);
    logic ack;
    bus_start();
    send_byte(DEV_W, ack); check(ack, {req, " device ack"}, ack, 1);
    send_byte(a[15:8], ack); check(ack, {req, " addr hi ack"}, ack, 1);
    send_byte(a[7:0], ack); check(ack, {req, " addr lo ack"}, ack, 1);
  endtask

  task automatic read_at(input logic [15:0] a, input logic [7:0] exp, input string req);
    logic ack;
    logic [7:0] d;
    set_addr(a, req);
    bus_start();
    send_byte(DEV_R, ack); check(ack, {req, " read device ack"}, ack, 1);
    recv_byte(1'b0, d); check(d == exp, {req, " read data"}, d, exp);
    bus_stop();
  endtask

  initial begin
    tick(WD);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic b;
    logic [7:0] d;
    tick(4);
    // R1: reset state
    check(sda_pull == 1'b0, "R1 reset releases line", sda_pull, 0);
    rst = 1'b0;
    tick(4);
    check(sda_pull == 1'b0, "R1 idle after reset", sda_pull, 0);

    // R5 R6 R3: table-driven write then readback, back-to-back transactions
    for (int v = 0; v < 6; v++) begin
      set_addr(VECS[v][23:8], "R5");
      send_byte(VECS[v][7:0], ack); check(ack, "R5 data ack", ack, 1);
      bus_stop();
      read_at(VECS[v][23:8], VECS[v][7:0], "R6");
    end

    // R4: upper address bits ignored (0xFC12 aliases 0x0012)
    read_at(16'h0012, 8'h81, "R4");

    // R3: strap mismatch gets no ack, line stays released
    bus_start();
    send_byte(8'hA2, ack); check(!ack, "R3 wrong strap no ack", ack, 0);
    send_byte(8'h00, ack); check(!ack, "R3 silent after mismatch", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'h5A, ack); check(!ack, "R3 wrong prefix no ack", ack, 0);
    bus_stop();

    // R7: sequential write across the top
    set_addr(16'h03FE, "R7");
    send_byte(8'h11, ack); check(ack, "R7 wr0 ack", ack, 1);
    send_byte(8'h22, ack); check(ack, "R7 wr1 ack", ack, 1);
    send_byte(8'h33, ack); check(ack, "R7 wr2 ack", ack, 1);
    bus_stop();
    // R7 R6: sequential read across the top
    set_addr(16'h03FE, "R7");
    bus_start();
    send_byte(DEV_R, ack); check(ack, "R7 read dev ack", ack, 1);
    recv_byte(1'b1, d); check(d == 8'h11, "R7 rd 0x3FE", d, 8'h11);
    recv_byte(1'b1, d); check(d == 8'h22, "R7 rd 0x3FF", d, 8'h22);
    recv_byte(1'b0, d); check(d == 8'h33, "R7 rd wrapped 0x000", d, 8'h33);
    bus_stop();

    // R8: current-address read continues at 0x001
    bus_start();
    send_byte(DEV_R, ack); check(ack, "R8 dev ack", ack, 1);
    recv_byte(1'b0, d); check(d == 8'h5A, "R8 current address data", d, 8'h5A);
    // R9: after master NACK the slave sends nothing
    recv_byte(1'b0, d); check(d == 8'hFF, "R9 silent after NACK", d, 8'hFF);
    bus_stop();

    // R10: Stop mid-byte does not write
    set_addr(16'h0123, "R10");
    bit_out(1'b0); bit_out(1'b0); bit_out(1'b0); bit_out(1'b0);
    bus_stop();
    read_at(16'h0123, 8'hC3, "R10 stop abort");

    // R10 R2: Start mid-byte restarts device matching, pointer kept
    set_addr(16'h0010, "R10");
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    bus_start();
    send_byte(DEV_R, ack); check(ack, "R10 restart dev ack", ack, 1);
    recv_byte(1'b0, d); check(d == 8'h66, "R10 no partial write", d, 8'h66);
    bus_stop();

    // R1: reset during a read byte releases the line
    read_at(16'h0200, 8'h3C, "R1 pre");
    bus_start();
    send_byte(DEV_R, ack); check(ack, "R1 dev ack", ack, 1);
    bit_in(b); bit_in(b); bit_in(b);
    rst = 1'b1; tick(3);
    check(sda_pull == 1'b0, "R1 reset mid-read", sda_pull, 0);
    rst = 1'b0; tick(2);
    bit_in(b); check(b == 1'b1, "R1 idle after reset", b, 1);
    bus_stop();
    read_at(16'h0001, 8'h5A, "R1 post");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule